// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Symbol Transmit Generator

This block drives the single wire of a variable-pulse-width serial bus. The upstream logic hands it one symbol at a time over a ready/valid request port. A request names the symbol kind and, for a data bit, its value. The generator holds the bus at the right level for that symbol's nominal length and then pulses `done`. Byte serialization, CRC and arbitration are handled upstream.

A data bit is encoded by both level and width. The generator keeps a level phase that starts passive at the beginning of a frame and flips after each data bit. From that phase and the bit value it picks a short or long, active or passive pulse. A normalization bit is valid only straight after end of data. If one arrives elsewhere, it is rejected with an error pulse and nothing goes on the bus. A break can be issued at any time. It cuts off the current symbol, drives the bus active at once, and is followed by an enforced idle gap before new requests are taken.

All durations are whole numbers of microseconds multiplied by a ticks-per-microsecond parameter. With the default of 24, each duration is exact to one 24 MHz clock.

Top module: `vpw_sym_tx`

## Requirements
- R1: After reset, `bus_out` is 0 (passive), `req_ready` is 1, and `done` and `seq_err` are 0.
- R2: Start of frame (code 0) drives `bus_out` = 1 for 200 us. End of data (code 2) drives it to 0 for 200 us. End of frame (code 5) drives it to 0 for 280 us.
- R3: Data bit level phase. The phase is passive after reset, after start of frame, after any normalization bit and after a break. Each data bit (code 1) is sent at the current phase level, and the phase then flips.
- R4: Data bit width. A bit sent at passive level lasts 64 us if it is 0 and 128 us if it is 1. A bit sent at active level lasts 128 us if it is 0 and 64 us if it is 1.
- R5: A short normalization bit (code 3) drives `bus_out` = 1 for 64 us. A long normalization bit (code 4) drives it to 1 for 128 us. Either one is transmitted only when the previously accepted request was end of data.
- R6: An accepted normalization request that does not directly follow end of data is not transmitted. It gives a one-cycle `seq_err` pulse, no `done` pulse, and the bus stays passive.
- R7: A break (code 6) is taken whenever `req_valid` is high, regardless of `req_ready`. From the next clock edge it drives `bus_out` = 1 for 300 us and aborts any symbol in progress without a `done` pulse for that symbol. It ends with a `done` pulse.
- R8: After a break completes, `bus_out` stays 0 and `req_ready` stays 0 for 300 us. After that the generator is idle.
- R9: A transmitted symbol holds its level for exactly its duration times TICKS_PER_US clock cycles. `done` is a one-cycle pulse in the first cycle after the symbol ends.
- R10: A non-break request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a symbol has more than one cycle left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (24 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Symbol request present |
| req_ready | output | 1 | Generator can take a non-break request this cycle |
| req_sym | input | 3 | Symbol code: 0 SOF, 1 data, 2 EOD, 3 short norm, 4 long norm, 5 EOF, 6 break |
| req_bit | input | 1 | Data bit value (used with code 1) |
| bus_out | output | 1 | Bus level, 1 = active |
| done | output | 1 | One-cycle pulse when a symbol finishes |
| seq_err | output | 1 | One-cycle pulse when a normalization request is rejected |

## Verification
A first frame sends bits 0,1,1,0. This walks all four level/value combinations, so a wrong phase start, a missing phase flip or swapped short/long widths each gives a different level or width. A second frame sends a long normalization bit and a data bit after it, which shows the phase resets after normalization and separates the short and long normalization widths. Normalization requests sent from idle and after a data bit must give the error pulse. A break issued in the middle of start of frame must cut the symbol short. After it, the bench checks the break width, the idle gap with ready held low, and that the next data bit starts passive.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;
  typedef enum logic [2:0] {
    SYM_SOF = 3'd0,
    SYM_BIT = 3'd1,
    SYM_EOD = 3'd2,
    SYM_NBS = 3'd3,
    SYM_NBL = 3'd4,
    SYM_EOF = 3'd5,
    SYM_BRK = 3'd6
  } vpw_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYM  = 2'd1,
    ST_GAP  = 2'd2
  } vpw_st_e;
endpackage

// File: rtl/vpw_sym_decode.sv
module vpw_sym_decode
  import vpw_tx_pkg::*;
#(
  parameter int CW        = 13,
  parameter int T_SHORT   = 1536,
  parameter int T_LONG    = 3072,
  parameter int T_FRAME   = 4800,
  parameter int T_EOF     = 6720
) (
  input  logic [2:0]    sym,
  input  logic          bit_val,
  input  logic          phase,
  output logic          level,
  output logic [CW-1:0] ticks,
  output logic          is_data,
  output logic          is_norm
);
  always_comb begin
    level   = 1'b0;
    ticks   = CW'(T_SHORT);
    is_data = 1'b0;
    is_norm = 1'b0;
    case (vpw_sym_e'(sym))
      SYM_SOF: begin level = 1'b1; ticks = CW'(T_FRAME); end
      SYM_BIT: begin
        is_data = 1'b1;
        level   = phase;
        // short when value matches level, long otherwise
        ticks   = (bit_val == phase) ? CW'(T_SHORT) : CW'(T_LONG);
      end
      SYM_EOD: begin level = 1'b0; ticks = CW'(T_FRAME); end
      SYM_NBS: begin level = 1'b1; ticks = CW'(T_SHORT); is_norm = 1'b1; end
      SYM_NBL: begin level = 1'b1; ticks = CW'(T_LONG);  is_norm = 1'b1; end
      SYM_EOF: begin level = 1'b0; ticks = CW'(T_EOF); end
      default: begin level = 1'b0; ticks = CW'(T_SHORT); end
    endcase
  end
endmodule

// File: rtl/vpw_tick_timer.sv
module vpw_tick_timer #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val - CW'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/vpw_sym_tx.sv
module vpw_sym_tx
  import vpw_tx_pkg::*;
#(
  parameter int TICKS_PER_US = 24,
  parameter int US_SHORT     = 64,
  parameter int US_LONG      = 128,
  parameter int US_FRAME     = 200,
  parameter int US_EOF       = 280,
  parameter int US_BRK       = 300,
  parameter int US_IDLE      = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_sym,
  input  logic       req_bit,
  output logic       bus_out,
  output logic       done,
  output logic       seq_err
);
  localparam int T_SHORT = US_SHORT * TICKS_PER_US;
  localparam int T_LONG  = US_LONG  * TICKS_PER_US;
  localparam int T_FRAME = US_FRAME * TICKS_PER_US;
  localparam int T_EOF   = US_EOF   * TICKS_PER_US;
  localparam int T_BRK   = US_BRK   * TICKS_PER_US;
  localparam int T_IDLE  = US_IDLE  * TICKS_PER_US;
  localparam int T_MAX   = (T_BRK > T_IDLE) ? T_BRK : T_IDLE;
  localparam int CW      = $clog2(T_MAX + 1);

  vpw_st_e       st_q;
  logic          phase_q, after_eod_q, is_brk_q;
  logic          dec_level, dec_data, dec_norm;
  logic [CW-1:0] dec_ticks;
  logic          tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  logic          brk_go, fire, sym_go, bad_norm, gap_go;

  vpw_sym_decode #(
    .CW(CW), .T_SHORT(T_SHORT), .T_LONG(T_LONG),
    .T_FRAME(T_FRAME), .T_EOF(T_EOF)
  ) u_dec (
    .sym(req_sym), .bit_val(req_bit), .phase(phase_q),
    .level(dec_level), .ticks(dec_ticks),
    .is_data(dec_data), .is_norm(dec_norm)
  );

  vpw_tick_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  // ready: idle, or last cycle of a non-break symbol (seamless chaining)
  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_SYM && tmr_zero && !is_brk_q);

  always_comb begin
    brk_go   = req_valid && (vpw_sym_e'(req_sym) == SYM_BRK);
    fire     = req_valid && req_ready && !brk_go;
    bad_norm = fire && dec_norm && !after_eod_q;
    sym_go   = fire && !bad_norm;
    gap_go   = !brk_go && st_q == ST_SYM && tmr_zero && is_brk_q;
    tmr_load = brk_go || sym_go || gap_go;
    if (brk_go)      tmr_val = CW'(T_BRK);
    else if (gap_go) tmr_val = CW'(T_IDLE);
    else             tmr_val = dec_ticks;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      bus_out     <= 1'b0;
      done        <= 1'b0;
      seq_err     <= 1'b0;
      phase_q     <= 1'b0;
      after_eod_q <= 1'b0;
      is_brk_q    <= 1'b0;
    end else begin
      done    <= 1'b0;
      seq_err <= 1'b0;
      if (brk_go) begin
        st_q        <= ST_SYM;
        is_brk_q    <= 1'b1;
        bus_out     <= 1'b1;
        phase_q     <= 1'b0;
        after_eod_q <= 1'b0;
      end else begin
        case (st_q)
          ST_SYM: if (tmr_zero) begin
            done    <= 1'b1;
            bus_out <= 1'b0;
            if (is_brk_q) begin
              st_q     <= ST_GAP;
              is_brk_q <= 1'b0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          ST_GAP: if (tmr_zero) st_q <= ST_IDLE;
          default: ;
        endcase
        if (fire) begin
          after_eod_q <= (vpw_sym_e'(req_sym) == SYM_EOD) && !bad_norm;
          if (bad_norm) begin
            seq_err <= 1'b1;
          end else begin
            st_q    <= ST_SYM;
            bus_out <= dec_level;
            if (dec_data) phase_q <= ~phase_q;
            else if (dec_norm || vpw_sym_e'(req_sym) == SYM_SOF) phase_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vpw_sym_tx_chk.sv
module vpw_sym_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_sym,
  input logic       bus_out,
  input logic       done,
  input logic       seq_err
);
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: break drives the bus active on the next edge
  p_brk_active_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sym == 3'd6) |=> bus_out);

  // R6: error only follows a normalization request, and bus stays passive
  p_err_src_r6: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> ($past(req_valid && (req_sym == 3'd3 || req_sym == 3'd4)) && !bus_out));

  // R10: bus moves only on a taken request or at a symbol end
  p_bus_moves_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_out) |-> ($past(req_valid && (req_ready || req_sym == 3'd6)) || done));
endmodule

bind vpw_sym_tx vpw_sym_tx_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_sym(req_sym), .bus_out(bus_out), .done(done), .seq_err(seq_err)
);

// File: tb/vpw_sym_tx_bench.sv
module vpw_sym_tx_bench;
  localparam int TPU = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_sym = 3'd0;
  logic       req_bit = 1'b0;
  logic       bus_out, done, seq_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vpw_sym_tx #(.TICKS_PER_US(TPU)) u_vpw_sym_tx (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sym(req_sym), .req_bit(req_bit), .bus_out(bus_out),
    .done(done), .seq_err(seq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive request at negedge, hold until accepted (R10)
  task automatic issue(input logic [2:0] s, input logic b);
    req_sym   = s;
    req_bit   = b;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // measure held level until done
  task automatic send(input logic [2:0] s, input logic b, input logic lvl,
                      input int us, input string req);
    int cnt = 0;
    int bad = 0;
    issue(s, b);
    while (!done && cnt < 2000) begin
      if (bus_out !== lvl) bad++;
      cnt++;
      @(negedge clk);
    end
    chk(bad == 0, req, bad, 0);
    chk(cnt == us * TPU, {req, " R9 width"}, cnt, us * TPU);
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse", done, 0);
  endtask

  task automatic t_reset();
    chk(bus_out == 1'b0 && req_ready == 1'b1 && done == 1'b0 && seq_err == 1'b0,
        "R1 reset state", {bus_out, req_ready, done, seq_err}, 4'b0100);
  endtask

  task automatic t_frame();
    send(3'd0, 1'b0, 1'b1, 200, "R2 SOF");
    send(3'd1, 1'b0, 1'b0, 64,  "R3 R4 bit0 passive");
    send(3'd1, 1'b1, 1'b1, 64,  "R3 R4 bit1 active");
    send(3'd1, 1'b1, 1'b0, 128, "R3 R4 bit1 passive");
    send(3'd1, 1'b0, 1'b1, 128, "R3 R4 bit0 active");
    send(3'd2, 1'b0, 1'b0, 200, "R2 EOD");
    send(3'd3, 1'b0, 1'b1, 64,  "R5 short norm");
    send(3'd1, 1'b0, 1'b0, 64,  "R3 phase after norm");
    send(3'd5, 1'b0, 1'b0, 280, "R2 EOF");
  endtask

  task automatic t_long_norm();
    send(3'd0, 1'b0, 1'b1, 200, "R2 SOF");
    send(3'd1, 1'b1, 1'b0, 128, "R4 bit1 passive");
    send(3'd2, 1'b0, 1'b0, 200, "R2 EOD");
    send(3'd4, 1'b0, 1'b1, 128, "R5 long norm");
    send(3'd1, 1'b1, 1'b0, 128, "R3 phase after long norm");
    send(3'd5, 1'b0, 1'b0, 280, "R2 EOF");
  endtask

  task automatic t_bad_norm();
    int dn = 0;
    int bz = 0;
    issue(3'd3, 1'b0);
    chk(seq_err == 1'b1, "R6 err from idle", seq_err, 1);
    for (int i = 0; i < 20; i++) begin
      if (done) dn++;
      if (bus_out) bz++;
      @(negedge clk);
    end
    chk(dn == 0 && bz == 0, "R6 no transmit", dn + bz, 0);
    chk(seq_err == 1'b0, "R6 err one cycle", seq_err, 0);
    send(3'd0, 1'b0, 1'b1, 200, "R2 SOF");
    send(3'd1, 1'b0, 1'b0, 64,  "R4 bit0 passive");
    issue(3'd4, 1'b0);
    chk(seq_err == 1'b1, "R6 err after data", seq_err, 1);
    chk(bus_out == 1'b0, "R6 bus passive", bus_out, 0);
  endtask

  task automatic t_break();
    int cnt = 0;
    int bad = 0;
    issue(3'd0, 1'b0);
    repeat (50) @(negedge clk);
    chk(req_ready == 1'b0, "R10 ready low mid symbol", req_ready, 0);
    req_sym = 3'd6; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cnt < 2000) begin
      if (!bus_out) bad++;
      cnt++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 break active", bad, 0);
    chk(cnt == 300 * TPU, "R7 break width, SOF aborted", cnt, 300 * TPU);
    cnt = 0; bad = 0;
    while (!req_ready && cnt < 2000) begin
      if (bus_out) bad++;
      cnt++;
      @(negedge clk);
    end
    chk(bad == 0, "R8 idle passive", bad, 0);
    chk(cnt == 300 * TPU, "R8 idle gap", cnt, 300 * TPU);
    send(3'd1, 1'b1, 1'b0, 128, "R3 phase after break");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_frame();
    t_long_norm();
    t_bad_norm();
    repeat (4) @(negedge clk);
    t_break();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule